// File: doc/BRIEF.md
# Paged Edge-Detect Digital I/O Controller

This block is a byte-wide register target that controls 48 open-drain digital lines. The lines are grouped into six 8-bit ports. Each port register drives its lines with inverted sense: a 1 pulls a line low, and a 0 lets it float high. Reading a port returns the synchronized pad level, inverted in the same way. A host reaches everything through a 16-location byte address space with one write strobe and a combinational read-data path.

The lines of the first three ports also carry edge detection. Each of these lines has a polarity bit, an enable bit and a sticky flag. The three register banks that hold these bits share a three-byte window at addresses 0x8 to 0xA. A page field decides which bank the window shows. That page field sits in a combined page/lock register at 0x7, and the same register's low bits can freeze individual ports against writes.

The flags are collected into a per-port pending summary at 0x6 and into a single active-high interrupt output. Software clears flags by writing zero bits into the interrupt-ID bank.

Top module: `edge_dio_ctrl`

## Requirements
- R1: Asserting `rst_n` (active low) has the following effects:
  - Every port register returns to 0, so no line is pulled low.
  - The page field returns to 0 and all lock bits clear.
  - Every polarity, enable and flag bit clears, and `irq` is 0.
- R2: A write to address k (0..5) loads port k. Bit i of that port controls `line_drive_low[8k+i]`, where a 1 pulls the line low and a 0 releases it.
- R3: A write to address 0x7 sets the page from data bits 7:6 and the lock bits from data bits 5:0. While lock bit k is 1, writes to port k have no effect.
- R4: A read of address k (0..5) returns the inverted level of the port's lines: 1 for a low line, 0 for a high line. The value is taken through a two-stage synchronizer, so a change on a line is visible two clock edges later.
- R5: The following reads return 0x00:
  - address 0x7;
  - addresses 0x8..0xA on pages 0, 1 and 2;
  - addresses 0xB..0xF.
- R6: A flag sets only on an edge-capable line whose enable bit is 1 and whose edge matches its polarity bit. A polarity of 1 selects a low-to-high level change and a polarity of 0 selects a high-to-low change. The flag is set on the third clock edge after the line changes.
- R7: Writes to window address 0x8+j (j = 0..2) reach the bank of port j selected by the page:
  - page 1: the polarity bank;
  - page 2: the enable bank;
  - page 3: the interrupt-ID flags, which are also readable there.
- R8: A write to window address 0x8+j on page 3 clears each flag whose data bit is 0 and leaves the flags whose data bit is 1. If an edge qualifies for a flag in the same cycle as the clear, the flag stays set.
- R9: Address 0x6 returns one pending bit per edge-capable port in bits 2:0, each the OR of that port's flags. `irq` is 1 exactly when any pending bit is 1.
- R10: Edges on ports 3..5 never set a flag or a pending bit.
- R11: Port registers can be read and written on every page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| line_in | input | 48 | Sensed pad levels (1 = high) |
| line_drive_low | output | 48 | Pull-low enables for the open-drain pads |
| irq | output | 1 | Active-high interrupt, OR of all flags |

## Verification
The bench builds the block with its default parameters: six ports of eight lines, three edge-capable ports and a two-stage synchronizer. With these values the full address map is in use: the pending register at 0x6, the page/lock register at 0x7, the window at 0x8–0xA and the unused locations above it. The bench models each open-drain pad as the AND of the block's release and an external pull-low source. Port writes therefore create real edges that loop back, while separate external pulls exercise the falling-edge polarity. It also times a flag clear to land on the same edge as a new qualifying edge.

// File: rtl/edio_pkg.sv
package edio_pkg;

  // Bank shown in the three-byte paged window
  typedef enum logic [1:0] {
    PAGE_IDLE = 2'd0,
    PAGE_POL  = 2'd1,
    PAGE_ENAB = 2'd2,
    PAGE_FLAG = 2'd3
  } page_e;

endpackage

// File: rtl/edio_regfile.sv
module edio_regfile
  import edio_pkg::*;
#(
  parameter int NUM_PORTS  = 6,
  parameter int PORT_W     = 8,
  parameter int EDGE_PORTS = 3,
  parameter int ADDR_W     = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 bus_wr,
  input  logic [ADDR_W-1:0]                    bus_addr,
  input  logic [PORT_W-1:0]                    bus_wdata,
  output page_e                                page,
  output logic [NUM_PORTS-1:0]                 lock,
  output logic [NUM_PORTS-1:0]                 port_we,
  output logic [EDGE_PORTS-1:0][PORT_W-1:0]    pol,
  output logic [EDGE_PORTS-1:0][PORT_W-1:0]    enab,
  output logic [EDGE_PORTS-1:0]                flag_clr_we
);

  localparam int PGLK_ADDR = NUM_PORTS + 1;
  localparam int WIN_BASE  = NUM_PORTS + 2;

  page_e                              page_q, page_d;
  logic [NUM_PORTS-1:0]               lock_q, lock_d;
  logic                               pglk_we;
  logic [EDGE_PORTS-1:0][PORT_W-1:0]  pol_q, pol_d, enab_q, enab_d;
  logic [EDGE_PORTS-1:0]              win_hit, pol_we, enab_we;

  // Port write strobes, gated by the lock bits
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port_we
    assign port_we[i] = bus_wr && (bus_addr == ADDR_W'(i)) && !lock_q[i];
  end

  assign pglk_we = bus_wr && (bus_addr == ADDR_W'(PGLK_ADDR));

  // Window decode per edge-capable port
  for (genvar j = 0; j < EDGE_PORTS; j++) begin : g_win
    assign win_hit[j]     = bus_wr && (bus_addr == ADDR_W'(WIN_BASE + j));
    assign pol_we[j]      = win_hit[j] && (page_q == PAGE_POL);
    assign enab_we[j]     = win_hit[j] && (page_q == PAGE_ENAB);
    assign flag_clr_we[j] = win_hit[j] && (page_q == PAGE_FLAG);
  end

  always_comb begin
    page_d = page_q;
    lock_d = lock_q;
    if (pglk_we) begin
      page_d = page_e'(bus_wdata[PORT_W-1 -: 2]);
      lock_d = bus_wdata[NUM_PORTS-1:0];
    end
    for (int j = 0; j < EDGE_PORTS; j++) begin
      pol_d[j]  = pol_we[j]  ? bus_wdata : pol_q[j];
      enab_d[j] = enab_we[j] ? bus_wdata : enab_q[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= PAGE_IDLE;
      lock_q <= '0;
      pol_q  <= '0;
      enab_q <= '0;
    end else begin
      page_q <= page_d;
      lock_q <= lock_d;
      pol_q  <= pol_d;
      enab_q <= enab_d;
    end
  end

  assign page = page_q;
  assign lock = lock_q;
  assign pol  = pol_q;
  assign enab = enab_q;

endmodule

// File: rtl/edio_port_bank.sv
module edio_port_bank #(
  parameter int NUM_PORTS  = 6,
  parameter int PORT_W     = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_PORTS-1:0]            port_we,
  input  logic [PORT_W-1:0]               wdata,
  input  logic [NUM_PORTS*PORT_W-1:0]     line_in,
  output logic [NUM_PORTS*PORT_W-1:0]     drive_low,
  output logic [NUM_PORTS*PORT_W-1:0]     line_sync
);

  localparam int LINES = NUM_PORTS * PORT_W;

  logic [NUM_PORTS-1:0][PORT_W-1:0] port_q, port_d;
  logic [LINES-1:0] sync_q [SYNC_DEPTH];
  logic [LINES-1:0] sync_d [SYNC_DEPTH];

  // Port output registers with explicit load enables
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    assign port_d[i] = port_we[i] ? wdata : port_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) port_q[i] <= '0;
      else        port_q[i] <= port_d[i];
    end

    assign drive_low[i*PORT_W +: PORT_W] = port_q[i];
  end

  // Input synchronizer; idles at the released (high) level
  always_comb begin
    sync_d[0] = line_in;
    for (int k = 1; k < SYNC_DEPTH; k++) sync_d[k] = sync_q[k-1];
  end

  for (genvar k = 0; k < SYNC_DEPTH; k++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[k] <= '1;
      else        sync_q[k] <= sync_d[k];
    end
  end

  assign line_sync = sync_q[SYNC_DEPTH-1];

endmodule

// File: rtl/edio_edge_unit.sv
module edio_edge_unit #(
  parameter int PORT_W     = 8,
  parameter int EDGE_PORTS = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [EDGE_PORTS*PORT_W-1:0]      level,
  input  logic [EDGE_PORTS-1:0][PORT_W-1:0] pol,
  input  logic [EDGE_PORTS-1:0][PORT_W-1:0] enab,
  input  logic [EDGE_PORTS-1:0]             clr_we,
  input  logic [PORT_W-1:0]                 clr_keep,
  output logic [EDGE_PORTS-1:0][PORT_W-1:0] flags
);

  for (genvar j = 0; j < EDGE_PORTS; j++) begin : g_edge
    logic [PORT_W-1:0] cur, prev_q, prev_d;
    logic [PORT_W-1:0] rise, fall, hit;
    logic [PORT_W-1:0] flag_q, flag_d;

    assign cur  = level[j*PORT_W +: PORT_W];
    assign rise = cur & ~prev_q;
    assign fall = ~cur & prev_q;
    assign hit  = enab[j] & ((pol[j] & rise) | (~pol[j] & fall));

    always_comb begin
      prev_d = cur;
      flag_d = clr_we[j] ? (flag_q & clr_keep) : flag_q;
      flag_d = flag_d | hit;   // a new edge outranks a clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= '1;
        flag_q <= '0;
      end else begin
        prev_q <= prev_d;
        flag_q <= flag_d;
      end
    end

    assign flags[j] = flag_q;
  end

endmodule

// File: rtl/edge_dio_ctrl.sv
module edge_dio_ctrl
  import edio_pkg::*;
#(
  parameter int NUM_PORTS  = 6,
  parameter int PORT_W     = 8,
  parameter int EDGE_PORTS = 3,
  parameter int SYNC_DEPTH = 2,
  parameter int ADDR_W     = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wr,
  input  logic [PORT_W-1:0]             bus_wdata,
  output logic [PORT_W-1:0]             bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0]   line_in,
  output logic [NUM_PORTS*PORT_W-1:0]   line_drive_low,
  output logic                          irq
);

  localparam int PEND_ADDR = NUM_PORTS;
  localparam int WIN_BASE  = NUM_PORTS + 2;
  localparam int LINES     = NUM_PORTS * PORT_W;
  localparam int EDGE_LINES = EDGE_PORTS * PORT_W;

  // Reset: asserted asynchronously, released after two clock edges
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  page_e                              page;
  logic [NUM_PORTS-1:0]               lock, port_we;
  logic [EDGE_PORTS-1:0][PORT_W-1:0]  pol, enab, flags;
  logic [EDGE_PORTS-1:0]              flag_clr_we, pending;
  logic [LINES-1:0]                   line_sync;

  edio_regfile #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W),
    .EDGE_PORTS(EDGE_PORTS), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .page(page), .lock(lock), .port_we(port_we),
    .pol(pol), .enab(enab), .flag_clr_we(flag_clr_we)
  );

  edio_port_bank #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .SYNC_DEPTH(SYNC_DEPTH)
  ) u_ports (
    .clk(clk), .rst_n(rst_sync_n),
    .port_we(port_we), .wdata(bus_wdata),
    .line_in(line_in), .drive_low(line_drive_low), .line_sync(line_sync)
  );

  edio_edge_unit #(
    .PORT_W(PORT_W), .EDGE_PORTS(EDGE_PORTS)
  ) u_edge (
    .clk(clk), .rst_n(rst_sync_n),
    .level(line_sync[EDGE_LINES-1:0]),
    .pol(pol), .enab(enab),
    .clr_we(flag_clr_we), .clr_keep(bus_wdata),
    .flags(flags)
  );

  for (genvar j = 0; j < EDGE_PORTS; j++) begin : g_pend
    assign pending[j] = |flags[j];
  end

  assign irq = |pending;

  // Read path
  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (bus_addr == ADDR_W'(i)) bus_rdata = ~line_sync[i*PORT_W +: PORT_W];
    end
    if (bus_addr == ADDR_W'(PEND_ADDR)) bus_rdata = PORT_W'(pending);
    for (int j = 0; j < EDGE_PORTS; j++) begin
      if ((bus_addr == ADDR_W'(WIN_BASE + j)) && (page == PAGE_FLAG))
        bus_rdata = flags[j];
    end
  end

endmodule

// File: rtl/edio_checker.sv
module edio_checker #(
  parameter int NUM_PORTS  = 6,
  parameter int PORT_W     = 8,
  parameter int EDGE_PORTS = 3,
  parameter int ADDR_W     = 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            bus_wr,
  input logic [ADDR_W-1:0]               bus_addr,
  input logic [PORT_W-1:0]               bus_wdata,
  input logic [PORT_W-1:0]               bus_rdata,
  input logic [NUM_PORTS-1:0]            lock,
  input logic [NUM_PORTS*PORT_W-1:0]     drive_low,
  input logic [EDGE_PORTS*PORT_W-1:0]    flags,
  input logic [EDGE_PORTS*PORT_W-1:0]    enab,
  input logic                            irq
);

  localparam int LAST_USED = NUM_PORTS + 1 + EDGE_PORTS;

  // R2: an unlocked write to port 0 appears on its drivers next cycle
  a_r2_port_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0 && !lock[0]) |=> (drive_low[PORT_W-1:0] == $past(bus_wdata)));

  // R3: a write to a locked port leaves every driver unchanged
  a_r3_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr < ADDR_W'(NUM_PORTS)) && lock[bus_addr]) |=> $stable(drive_low));

  // R5: locations above the paged window read as zero
  a_r5_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > ADDR_W'(LAST_USED)) |-> (bus_rdata == '0));

  // R6: a flag only rises where the enable bit was set
  a_r6_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags) & ~$past(enab)) == '0));

  // R9: the interrupt never fires without a latched flag
  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0));

endmodule

bind edge_dio_ctrl edio_checker #(
  .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W),
  .EDGE_PORTS(EDGE_PORTS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .lock(lock), .drive_low(line_drive_low),
  .flags(flags), .enab(enab), .irq(irq)
);

// File: tb/edge_dio_ctrl_test.sv
module edge_dio_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [47:0] line_in;
  logic [47:0] line_drive_low;
  logic [47:0] ext_low;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  // Open-drain pad: high only when nobody pulls it low
  assign line_in = ~(line_drive_low | ext_low);

  edge_dio_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .line_in(line_in),
    .line_drive_low(line_drive_low), .irq(irq)
  );

  // {is_write, addr, wdata, expected read}
  localparam int NV = 47;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 4'h0, 8'hA5, 8'h00},  //  0 R2 port 0
    {1'b0, 4'h0, 8'h00, 8'hA5},  //  1 R4 inverted readback
    {1'b1, 4'h3, 8'h3C, 8'h00},  //  2 R2 port 3
    {1'b0, 4'h3, 8'h00, 8'h3C},  //  3 R4
    {1'b1, 4'h7, 8'h01, 8'h00},  //  4 R3 lock port 0
    {1'b1, 4'h0, 8'hFF, 8'h00},  //  5 R3 ignored write
    {1'b0, 4'h0, 8'h00, 8'hA5},  //  6 R3 unchanged
    {1'b1, 4'h7, 8'h00, 8'h00},  //  7 R3 unlock
    {1'b1, 4'h0, 8'h00, 8'h00},  //  8
    {1'b0, 4'h0, 8'h00, 8'h00},  //  9 R2 released
    {1'b0, 4'h7, 8'h00, 8'h00},  // 10 R5 page/lock reads 0
    {1'b0, 4'hB, 8'h00, 8'h00},  // 11 R5 unused
    {1'b0, 4'h8, 8'h00, 8'h00},  // 12 R5 page 0 window
    {1'b1, 4'h7, 8'h40, 8'h00},  // 13 R7 page 1
    {1'b1, 4'h8, 8'hFF, 8'h00},  // 14 R7 port0 rising polarity
    {1'b0, 4'h8, 8'h00, 8'h00},  // 15 R5 polarity write-only
    {1'b1, 4'h7, 8'h80, 8'h00},  // 16 R7 page 2
    {1'b1, 4'h8, 8'h0F, 8'h00},  // 17 R7 enable low nibble
    {1'b0, 4'h3, 8'h00, 8'h3C},  // 18 R11 port read on page 2
    {1'b1, 4'h7, 8'hC0, 8'h00},  // 19 R7 page 3
    {1'b1, 4'h0, 8'h0F, 8'h00},  // 20 R6 falling edges, rising polarity
    {1'b0, 4'h8, 8'h00, 8'h00},  // 21 R6 no flag
    {1'b1, 4'h0, 8'h00, 8'h00},  // 22 R6 rising edges
    {1'b0, 4'h8, 8'h00, 8'h0F},  // 23 R6 flags set
    {1'b0, 4'h6, 8'h00, 8'h01},  // 24 R9 pending
    {1'b1, 4'h0, 8'hF0, 8'h00},  // 25 R6 disabled bits fall
    {1'b1, 4'h0, 8'h00, 8'h00},  // 26 R6 disabled bits rise
    {1'b0, 4'h8, 8'h00, 8'h0F},  // 27 R6 still only enabled bits
    {1'b1, 4'h8, 8'h0E, 8'h00},  // 28 R8 clear bit 0
    {1'b0, 4'h8, 8'h00, 8'h0E},  // 29 R8
    {1'b1, 4'h8, 8'h00, 8'h00},  // 30 R8 clear all
    {1'b0, 4'h8, 8'h00, 8'h00},  // 31 R8
    {1'b0, 4'h6, 8'h00, 8'h00},  // 32 R9 pending clear
    {1'b1, 4'h4, 8'hFF, 8'h00},  // 33 R10 port 4 falls
    {1'b1, 4'h4, 8'h00, 8'h00},  // 34 R10 port 4 rises
    {1'b0, 4'h6, 8'h00, 8'h00},  // 35 R10 nothing pending
    {1'b1, 4'h7, 8'h40, 8'h00},  // 36
    {1'b1, 4'h9, 8'h00, 8'h00},  // 37 R6 port1 falling polarity
    {1'b1, 4'h7, 8'h80, 8'h00},  // 38
    {1'b1, 4'h9, 8'hFF, 8'h00},  // 39 R7 port1 enables
    {1'b1, 4'h7, 8'hC0, 8'h00},  // 40
    {1'b1, 4'h1, 8'h01, 8'h00},  // 41 R6 line 8 falls
    {1'b0, 4'h9, 8'h00, 8'h01},  // 42 R6 falling flag
    {1'b0, 4'h6, 8'h00, 8'h02},  // 43 R9 pending port1
    {1'b0, 4'hA, 8'h00, 8'h00},  // 44 R7 port2 flags
    {1'b1, 4'h3, 8'h00, 8'h00},  // 45 R11 port write on page 3
    {1'b0, 4'h3, 8'h00, 8'h00}   // 46 R11
  };

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read(input logic [3:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(bus_rdata == e, req, 48'(bus_rdata), 48'(e));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; ext_low = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(line_drive_low == '0, "R1 drivers", line_drive_low, 48'h0);
    check(irq == 1'b0, "R1 irq", 48'(irq), 48'h0);
    do_read(4'h6, 8'h00, "R1 pending");

    // Table walk
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][20]) do_write(VEC[k][19:16], VEC[k][15:8]);
      else            do_read(VEC[k][19:16], VEC[k][7:0], $sformatf("table vector %0d", k));
    end

    // R9 interrupt follows the latched port1 flag
    #1;
    check(irq == 1'b1, "R9 irq set", 48'(irq), 48'h1);
    // R2 line mapping of port 1
    check(line_drive_low[15:8] == 8'h01, "R2 port1 lines", 48'(line_drive_low[15:8]), 48'h1);

    // R6 external pull-low on port 2 with falling polarity
    do_write(4'h7, 8'h40);
    do_write(4'hA, 8'h00);
    do_write(4'h7, 8'h80);
    do_write(4'hA, 8'h03);
    do_write(4'h7, 8'hC0);
    @(negedge clk);
    ext_low[16] = 1'b1;
    repeat (5) @(negedge clk);
    do_read(4'h6, 8'h06, "R6 R9 pending ports 1 and 2");
    do_read(4'hA, 8'h01, "R6 port2 flag");
    do_write(4'hA, 8'h00);
    do_read(4'hA, 8'h00, "R8 port2 cleared");

    // R8 a clear landing on the same edge as a new edge keeps the flag
    @(negedge clk);
    ext_low[17] = 1'b1;           // before edge e1
    @(negedge clk);               // after e1
    @(negedge clk);               // after e2
    bus_addr = 4'hA; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(negedge clk);               // after e3: flag set and clear coincide
    bus_wr = 1'b0;
    do_read(4'hA, 8'h02, "R8 edge wins over clear");

    // R1 reset in mid-run
    ext_low = '0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(line_drive_low == '0, "R1 drivers after reset", line_drive_low, 48'h0);
    check(irq == 1'b0, "R1 irq after reset", 48'(irq), 48'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(4'h6, 8'h00, "R1 pending after reset");
    do_read(4'h9, 8'h00, "R1 R5 page 0 after reset");
    do_write(4'h7, 8'hC0);
    do_read(4'h9, 8'h00, "R1 flags after reset");

    done = 1'b1;
    finish_run();
  end

endmodule